// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block sits beside a RAM shared by two ports, called left and right, and turns the two topmost RAM words into mailboxes. The top address (all ones) is the right port's mailbox. The address one below it is the left port's mailbox. When one port writes into the other port's mailbox word, the owner of that word gets an interrupt. The owner clears the interrupt by reading its own mailbox. The message itself stays in the ordinary RAM word. This logic never sees the data, so any value written raises the interrupt.

The block watches each port's enable, write strobe, address and the busy flag that the contention arbiter returns to that port. It drives one active-low interrupt line per port. A port whose busy flag is raised loses the location it is accessing in that cycle. Its access then neither raises the peer's interrupt nor clears its own. Every port pin is sampled on the rising clock edge, and each interrupt line is a register output that changes at that same edge. The block has no data path, so it has no stream interface. All pins are plain level signals with no handshake.

Top module: `dpram_mailbox_irq`

## Requirements
- R1: While reset is asserted and at the first edge after reset, both `l_int_n` and `r_int_n` are high, which means no interrupt is pending.
- R2: An access on the left port samples `l_en`=1, `l_we`=1, `l_addr` = all ones and `l_busy`=0 at a rising edge. After that edge `r_int_n` is low, and it stays low until it is cleared.
- R3: An access on the right port samples `r_en`=1, `r_we`=1, `r_addr` = all ones minus one and `r_busy`=0 at a rising edge. After that edge `l_int_n` is low.
- R4: An owner read clears the owner's interrupt line to high after the edge. For the right port this is `r_en`=1, `r_we`=0, `r_addr` = all ones, `r_busy`=0. For the left port it is the same pattern on the left pins, with address all ones minus one.
- R5: A port that reads the other port's mailbox word leaves both interrupt lines unchanged.
- R6: A mailbox write made while the writer's busy flag is high does not raise the peer's interrupt.
- R7: An owner read of its own mailbox made while the owner's busy flag is high does not clear its interrupt.
- R8: One port may write the other's mailbox in the same cycle that the owner reads that mailbox. In that case the set wins and the owner's interrupt is low after the edge.
- R9: A port that writes its own mailbox word leaves both interrupt lines unchanged.
- R10: Accesses with enable low, or to any address below the two mailbox words, leave both interrupt lines unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all pins sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| l_en | input | 1 | Left port access enable, active high |
| l_we | input | 1 | Left port write strobe (1 write, 0 read) |
| l_addr | input | AW | Left port word address |
| l_busy | input | 1 | Arbiter busy flag for the left port, active high |
| r_en | input | 1 | Right port access enable, active high |
| r_we | input | 1 | Right port write strobe (1 write, 0 read) |
| r_addr | input | AW | Right port word address |
| r_busy | input | 1 | Arbiter busy flag for the right port, active high |
| l_int_n | output | 1 | Left port interrupt, active low, registered |
| r_int_n | output | 1 | Right port interrupt, active low, registered |

## Verification
The hardest case to reach from the ports is a collision on one mailbox word. One port writes it while the owner reads it in the same cycle, and the busy flags decide which of the two accesses counts. With uniformly random addresses this collision almost never happens. The stimulus therefore draws each address mostly from the two mailbox words and sets the busy flags at a high rate. Directed steps also force the set-over-clear case and both busy-blocked cases while an interrupt is already pending.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef enum logic {
    SIDE_LEFT  = 1'b0,
    SIDE_RIGHT = 1'b1
  } side_e;

  // Decoded effect of one port's access in the current cycle.
  typedef struct packed {
    logic ring_peer;  // raise the opposite port's interrupt
    logic ack_own;    // clear this port's own interrupt
  } mbx_req_t;

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
  import mbx_pkg::*;
#(
  parameter int    AW   = 15,
  parameter side_e SIDE = SIDE_LEFT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          we,
  input  logic          busy,
  input  logic [AW-1:0] addr,
  output mbx_req_t      req
);

  localparam logic [AW-1:0] TOP_WORD  = {AW{1'b1}};
  localparam logic [AW-1:0] NEXT_WORD = TOP_WORD - 1'b1;
  localparam logic [AW-1:0] OWN_WORD  = (SIDE == SIDE_RIGHT) ? TOP_WORD : NEXT_WORD;
  localparam logic [AW-1:0] PEER_WORD = (SIDE == SIDE_RIGHT) ? NEXT_WORD : TOP_WORD;

  logic granted;
  logic hit_own;
  logic hit_peer;

  always_comb begin
    granted       = en && !busy;
    hit_own       = (addr == OWN_WORD);
    hit_peer      = (addr == PEER_WORD);
    req.ring_peer = granted && we && hit_peer;
    req.ack_own   = granted && !we && hit_own;
  end

  // R6 / R7: a port that lost arbitration produces no mailbox effect
  p_busy_silences_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (req == '0));

  // R9: writing the own mailbox word is inert
  p_own_write_inert_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && we && addr == OWN_WORD) |-> (req == '0));

  // R10: disabled port never acts
  p_idle_inert_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (req == '0));

endmodule

// File: rtl/mbx_irq_flag.sv
module mbx_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic irq_n
);

  always_ff @(posedge clk) begin
    if (!rst_n)      irq_n <= 1'b1;
    else if (set)    irq_n <= 1'b0;   // set outranks clear
    else if (clr)    irq_n <= 1'b1;
  end

  // R8: set wins over a simultaneous clear
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> !irq_n);

  // R4: a lone clear releases the line
  p_clear_releases_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> irq_n);

  // R5: without a request the line holds
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!set && !clr) |=> $stable(irq_n));

endmodule

// File: rtl/dpram_mailbox_irq.sv
module dpram_mailbox_irq
  import mbx_pkg::*;
#(
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_en,
  input  logic          l_we,
  input  logic [AW-1:0] l_addr,
  input  logic          l_busy,
  input  logic          r_en,
  input  logic          r_we,
  input  logic [AW-1:0] r_addr,
  input  logic          r_busy,
  output logic          l_int_n,
  output logic          r_int_n
);

  localparam int              NPORT     = 2;
  localparam logic [AW-1:0]   TOP_WORD  = {AW{1'b1}};
  localparam logic [AW-1:0]   NEXT_WORD = TOP_WORD - 1'b1;

  logic [NPORT-1:0] en_a, we_a, busy_a, irq_n_a;
  logic [AW-1:0]    addr_a [NPORT];
  mbx_req_t         req_a  [NPORT];

  always_comb begin
    en_a      = {r_en, l_en};
    we_a      = {r_we, l_we};
    busy_a    = {r_busy, l_busy};
    addr_a[0] = l_addr;
    addr_a[1] = r_addr;
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    mbx_port_decode #(
      .AW   (AW),
      .SIDE (side_e'(p))
    ) u_dec (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en_a[p]),
      .we    (we_a[p]),
      .busy  (busy_a[p]),
      .addr  (addr_a[p]),
      .req   (req_a[p])
    );

    mbx_irq_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (req_a[NPORT-1-p].ring_peer),
      .clr   (req_a[p].ack_own),
      .irq_n (irq_n_a[p])
    );
  end

  assign l_int_n = irq_n_a[0];
  assign r_int_n = irq_n_a[1];

  // R2: right interrupt only falls after a granted left write to the top word
  p_r_fall_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(r_int_n) |-> $past(l_en && l_we && !l_busy && l_addr == TOP_WORD));

  // R3: left interrupt only falls after a granted right write to the next word
  p_l_fall_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(l_int_n) |-> $past(r_en && r_we && !r_busy && r_addr == NEXT_WORD));

  // R4: right interrupt only rises after the right port reads its own word
  p_r_rise_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(r_int_n) |-> $past(r_en && !r_we && !r_busy && r_addr == TOP_WORD));

  // R4: left interrupt only rises after the left port reads its own word
  p_l_rise_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(l_int_n) |-> $past(l_en && !l_we && !l_busy && l_addr == NEXT_WORD));

endmodule

// File: tb/test_dpram_mailbox_irq.sv
module test_dpram_mailbox_irq;

  localparam int AW = 15;
  localparam logic [AW-1:0] TOPW  = {AW{1'b1}};
  localparam logic [AW-1:0] NEXTW = TOPW - 1'b1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_en = 0, l_we = 0, l_busy = 0, r_en = 0, r_we = 0, r_busy = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_int_n, r_int_n;

  int n_chk = 0;
  int n_bad = 0;
  bit exp_l = 0;  // 1 = left interrupt pending
  bit exp_r = 0;

  always #4 clk = ~clk;  // 125 MHz

  dpram_mailbox_irq #(.AW(AW)) i_dpram_mailbox_irq (
    .clk, .rst_n, .l_en, .l_we, .l_addr, .l_busy,
    .r_en, .r_we, .r_addr, .r_busy, .l_int_n, .r_int_n
  );

  // Next pending state from the requirements: set beats clear.
  function automatic bit next_pend(bit cur, bit set, bit clr);
    if (set) return 1'b1;
    if (clr) return 1'b0;
    return cur;
  endfunction

  task automatic check(string tag);
    n_chk++;
    if (l_int_n !== !exp_l) begin
      n_bad++;
      $display("FAIL %s l_int_n actual=%b expected=%b", tag, l_int_n, !exp_l);
    end
    n_chk++;
    if (r_int_n !== !exp_r) begin
      n_bad++;
      $display("FAIL %s r_int_n actual=%b expected=%b", tag, r_int_n, !exp_r);
    end
  endtask

  task automatic apply(bit le, bit lw, logic [AW-1:0] la, bit lb,
                       bit re, bit rw, logic [AW-1:0] ra, bit rb, string tag);
    bit set_r, clr_r, set_l, clr_l;
    @(negedge clk);
    l_en = le; l_we = lw; l_addr = la; l_busy = lb;
    r_en = re; r_we = rw; r_addr = ra; r_busy = rb;
    set_r = le && lw && !lb && la == TOPW;
    clr_r = re && !rw && !rb && ra == TOPW;
    set_l = re && rw && !rb && ra == NEXTW;
    clr_l = le && !lw && !lb && la == NEXTW;
    exp_r = next_pend(exp_r, set_r, clr_r);
    exp_l = next_pend(exp_l, set_l, clr_l);
    @(posedge clk);
    #2;
    check(tag);
  endtask

  function automatic logic [AW-1:0] pick_addr();
    int k = $urandom_range(0, 9);
    if (k < 4) return TOPW;
    if (k < 8) return NEXTW;
    return AW'($urandom);
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #2;
    check("R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    apply(0,0,'0,0, 0,0,'0,0, "R1 after reset");
    apply(1,1,TOPW,0, 0,0,'0,0, "R2 left rings right");
    apply(1,0,TOPW,0, 0,0,'0,0, "R5 left reads right mailbox");
    apply(0,0,'0,0, 1,0,TOPW,1, "R7 busy right read keeps irq");
    apply(0,0,'0,0, 1,0,TOPW,0, "R4 right read clears");
    apply(0,0,'0,0, 1,1,NEXTW,1, "R6 busy right write no set");
    apply(0,0,'0,0, 1,1,NEXTW,0, "R3 right rings left");
    apply(0,0,'0,0, 1,0,NEXTW,0, "R5 right reads left mailbox");
    apply(1,0,NEXTW,1, 0,0,'0,0, "R7 busy left read keeps irq");
    apply(1,1,NEXTW,0, 1,1,TOPW,0, "R9 both write own mailbox");
    apply(1,1,TOPW,0, 1,0,TOPW,0, "R8 set beats clear");
    apply(1,0,NEXTW,0, 0,0,'0,0, "R4 left read clears");
    apply(0,1,NEXTW,0, 0,1,TOPW,0, "R10 disabled ports");
    apply(1,1,AW'(5),0, 1,0,AW'(7),0, "R10 ordinary addresses");
    apply(1,1,TOPW,1, 1,0,TOPW,0, "R6 busy writer vs owner read");
    apply(1,0,TOPW,0, 1,1,NEXTW,0, "R3 ring left while left reads peer");
    for (int i = 0; i < 3000; i++) begin
      apply($urandom_range(0,3) != 0, $urandom_range(0,1), pick_addr(), $urandom_range(0,3) == 0,
            $urandom_range(0,3) != 0, $urandom_range(0,1), pick_addr(), $urandom_range(0,3) == 0,
            "random mix");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule